// File: doc/BRIEF.md
# Video Receiver Interrupt Controller

This block collects single-cycle event strobes from a video receiver and turns them into one interrupt pin. It serves link-state logic (mode changes, sync stability, 5 V presence), the packet decoder (info-frame arrivals, mute commands) and the content-protection engine (authentication progress, error flags). Events land in three sticky status registers. Each status register has its own mask register.

A bit that is set and unmasked drives the interrupt. The interrupt is registered before it reaches the pin. Software can make the pin push-pull or open-drain, and active-high or active-low. Software clears latched events by writing group clear bits, not single status bits.

For the five info-packet types, a per-type mode bit decides how arrivals are filtered:
- In mode 0, an arrival raises its flag only when the decoder marks the content as new. This covers the first packet and any packet whose content has changed.
- In mode 1, every arrival raises its flag.

Top module: `vrx_irq_ctrl`

## Requirements
- R1: Link events `evt_link[5:0]` are latched into status register 0 (read address 0) on the clock edge where they are high, at the same bit positions: 0 = 5 V present, 1 = 5 V lost, 2 = sync gained, 3 = sync lost, 4 = HDMI/DVI change, 5 = video mode change. Latched bits stay set until cleared.
- R2: Status register 1 (read address 1) latches packet events at these bit positions: 0 = set-mute (`evt_mute[0]`), 1 = no video-info (`evt_no_vinfo`), 2..6 = filtered arrivals of packet types 0..4 (video-info, MPEG, SPD, ACP, audio), 7 = clear-mute (`evt_mute[1]`).
- R3: A packet mode register sits at address 8, with bits [4:0] for types 0..4. When a type's mode bit is 0, an arrival on `pkt_rx[i]` sets its status bit only if `pkt_chg[i]` is also high. When the mode bit is 1, every arrival sets it. All mode bits reset to 0.
- R4: Security events `evt_sec[5:0]` are latched into status register 2 (read address 2) at these bit positions: 0 = auth start, 1 = auth done, 2 = ECC error, 3 = audio FIFO error, 4 = audio auto-mute, 5 = ROM fault.
- R5: The mask registers are at addresses 3, 4 and 5, and a mask bit of 1 enables the matching status bit. The interrupt is active when any status bit is set together with its mask bit. The masks reset to 0x3F, 0x00 and 0x00.
- R6: Writing 1s to the clear register (address 7) clears groups of status bits; all other bits keep their values.

  | Clear bit | Group | Status bits cleared |
  |---|---|---|
  | 0 | mode | all of status 0 |
  | 1 | packet | status 1 bits 1..6 |
  | 2 | ECC | status 2 bit 2 |
  | 3 | audio | status 2 bits 3 and 4 |
  | 4 | clear-mute | status 1 bit 7 |
  | 5 | set-mute | status 1 bit 0 |
  | 6 | authentication | status 2 bits 0, 1 and 5 |

- R7: An event that arrives on the same edge as a clear of its bit leaves the bit set.
- R8: Pin control is at address 6. Bit 0 = 1 selects open-drain, in which case `irq_oe` is high only while the interrupt is active and `irq_o` holds the active level. Bit 0 = 0 selects push-pull, in which case `irq_oe` is always 1. Bit 1 = 1 makes the pin active-low. Both bits reset to 1.
- R9: The pin reflects the masked status one clock edge after the status register changes. An event strobe therefore reaches the pin on the second edge.
- R10: After reset, all status registers read 0. Writes to status addresses 0..2 have no effect, and the clear register reads back 0. Read data appears one edge after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| evt_link | input | 6 | Link event strobes |
| evt_sec | input | 6 | Security/audio event strobes |
| evt_mute | input | 2 | Mute packet strobes: bit 0 set-mute, bit 1 clear-mute |
| evt_no_vinfo | input | 1 | No video-info packet strobe |
| pkt_rx | input | 5 | Packet arrival strobes, types 0..4 |
| pkt_chg | input | 5 | Content new/changed qualifier, per type |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
Two functions can fall in the same cycle: an event strobe and a software clear of the group that holds it. The bench provokes this by raising a link strobe and writing the mode-group clear on the same clock edge. It judges the result by reading status 0 back, which must still hold the new event's bit while the older bits are gone.

A second collision is a packet arrival, in one filter mode, while that type's mode bit sits beside arrivals of other types. This case is judged by the exact value of status 1.

// File: rtl/vrx_irq_pkg.sv
package vrx_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int N_LINK   = 6;
  localparam int N_PKT    = 5;
  localparam int N_SEC    = 6;
  localparam int N_CLR    = 7;

  localparam int ADR_ST0  = 0;
  localparam int ADR_ST1  = 1;
  localparam int ADR_ST2  = 2;
  localparam int ADR_MSK0 = 3;
  localparam int ADR_MSK1 = 4;
  localparam int ADR_MSK2 = 5;
  localparam int ADR_PIN  = 6;
  localparam int ADR_CLR  = 7;
  localparam int ADR_MODE = 8;

  // clear group positions
  localparam int CG_MODE = 0;
  localparam int CG_PKT  = 1;
  localparam int CG_ECC  = 2;
  localparam int CG_AUD  = 3;
  localparam int CG_CMUT = 4;
  localparam int CG_SMUT = 5;
  localparam int CG_AUTH = 6;
endpackage

// File: rtl/vrx_irq_sticky.sv
module vrx_irq_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] st
);
  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= (st & ~clr) | evt;
  end

  // a set bit without a clear stays set
  assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st & $past(st & ~clr)) == $past(st & ~clr)));

  // an event wins over a clear on the same edge
  assert_evt_over_clr_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st & $past(evt)) == $past(evt)));
endmodule

// File: rtl/vrx_irq_pkt_gate.sv
module vrx_irq_pkt_gate #(
  parameter int N = 5
) (
  input  logic [N-1:0] pkt_rx,
  input  logic [N-1:0] pkt_chg,
  input  logic [N-1:0] every_mode,
  output logic [N-1:0] fire
);
  for (genvar i = 0; i < N; i++) begin : g_type
    always_comb fire[i] = pkt_rx[i] & (every_mode[i] | pkt_chg[i]);
  end
endmodule

// File: rtl/vrx_irq_regfile.sv
module vrx_irq_regfile
  import vrx_irq_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NL  = N_LINK,
  parameter int NP  = N_PKT,
  parameter int NS  = N_SEC,
  parameter int NC  = N_CLR,
  localparam int NB = NP + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NL-1:0] st0,
  input  logic [NB-1:0] st1,
  input  logic [NS-1:0] st2,
  output logic [NL-1:0] msk0,
  output logic [NB-1:0] msk1,
  output logic [NS-1:0] msk2,
  output logic [NC-1:0] clr,
  output logic [NP-1:0] pkt_mode,
  output logic          od_mode,
  output logic          act_low
);
  logic wr_msk0, wr_msk1, wr_msk2, wr_pin, wr_mode, wr_clr;

  always_comb begin
    wr_msk0 = reg_wr && (reg_addr == AW'(ADR_MSK0));
    wr_msk1 = reg_wr && (reg_addr == AW'(ADR_MSK1));
    wr_msk2 = reg_wr && (reg_addr == AW'(ADR_MSK2));
    wr_pin  = reg_wr && (reg_addr == AW'(ADR_PIN));
    wr_mode = reg_wr && (reg_addr == AW'(ADR_MODE));
    wr_clr  = reg_wr && (reg_addr == AW'(ADR_CLR));
    clr     = wr_clr ? reg_wdata[NC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msk0     <= '1;
      msk1     <= '0;
      msk2     <= '0;
      pkt_mode <= '0;
      od_mode  <= 1'b1;
      act_low  <= 1'b1;
    end else begin
      if (wr_msk0) msk0 <= reg_wdata[NL-1:0];
      if (wr_msk1) msk1 <= reg_wdata[NB-1:0];
      if (wr_msk2) msk2 <= reg_wdata[NS-1:0];
      if (wr_mode) pkt_mode <= reg_wdata[NP-1:0];
      if (wr_pin) begin
        od_mode <= reg_wdata[0];
        act_low <= reg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      case (reg_addr)
        AW'(ADR_ST0):  reg_rdata <= DW'(st0);
        AW'(ADR_ST1):  reg_rdata <= DW'(st1);
        AW'(ADR_ST2):  reg_rdata <= DW'(st2);
        AW'(ADR_MSK0): reg_rdata <= DW'(msk0);
        AW'(ADR_MSK1): reg_rdata <= DW'(msk1);
        AW'(ADR_MSK2): reg_rdata <= DW'(msk2);
        AW'(ADR_PIN):  reg_rdata <= DW'({act_low, od_mode});
        AW'(ADR_MODE): reg_rdata <= DW'(pkt_mode);
        default:       reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vrx_irq_pin.sv
module vrx_irq_pin (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic od_mode,
  input  logic act_low,
  output logic irq_o,
  output logic irq_oe
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend;
  end

  always_comb begin
    if (od_mode) begin
      irq_oe = irq_q;
      irq_o  = ~act_low;
    end else begin
      irq_oe = 1'b1;
      irq_o  = irq_q ^ act_low;
    end
  end
endmodule

// File: rtl/vrx_irq_ctrl.sv
module vrx_irq_ctrl
  import vrx_irq_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NL  = N_LINK,
  parameter int NP  = N_PKT,
  parameter int NS  = N_SEC,
  localparam int NB = NP + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NL-1:0] evt_link,
  input  logic [NS-1:0] evt_sec,
  input  logic [1:0]    evt_mute,
  input  logic          evt_no_vinfo,
  input  logic [NP-1:0] pkt_rx,
  input  logic [NP-1:0] pkt_chg,
  output logic          irq_o,
  output logic          irq_oe
);
  logic [NL-1:0]    st0, msk0, clr0;
  logic [NB-1:0]    st1, msk1, clr1, ev1;
  logic [NS-1:0]    st2, msk2, clr2;
  logic [N_CLR-1:0] clr;
  logic [NP-1:0]    pkt_mode, fire;
  logic             od_mode, act_low, pend;

  vrx_irq_regfile #(.DW(DW), .AW(AW), .NL(NL), .NP(NP), .NS(NS), .NC(N_CLR)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st0(st0), .st1(st1), .st2(st2),
    .msk0(msk0), .msk1(msk1), .msk2(msk2), .clr(clr),
    .pkt_mode(pkt_mode), .od_mode(od_mode), .act_low(act_low)
  );

  vrx_irq_pkt_gate #(.N(NP)) u_gate (
    .pkt_rx(pkt_rx), .pkt_chg(pkt_chg), .every_mode(pkt_mode), .fire(fire)
  );

  // group clear fan-out
  always_comb begin
    clr0 = {NL{clr[CG_MODE]}};
    clr1 = {clr[CG_CMUT], {NP+1{clr[CG_PKT]}}, clr[CG_SMUT]};
    clr2 = '0;
    clr2[0] = clr[CG_AUTH];
    clr2[1] = clr[CG_AUTH];
    clr2[2] = clr[CG_ECC];
    clr2[3] = clr[CG_AUD];
    clr2[4] = clr[CG_AUD];
    clr2[5] = clr[CG_AUTH];
    ev1     = {evt_mute[1], fire, evt_no_vinfo, evt_mute[0]};
  end

  vrx_irq_sticky #(.W(NL)) u_st0 (.clk(clk), .rst(rst), .evt(evt_link), .clr(clr0), .st(st0));
  vrx_irq_sticky #(.W(NB)) u_st1 (.clk(clk), .rst(rst), .evt(ev1),      .clr(clr1), .st(st1));
  vrx_irq_sticky #(.W(NS)) u_st2 (.clk(clk), .rst(rst), .evt(evt_sec),  .clr(clr2), .st(st2));

  always_comb pend = |{st0 & msk0, st1 & msk1, st2 & msk2};

  vrx_irq_pin u_pin (
    .clk(clk), .rst(rst), .pend(pend), .od_mode(od_mode), .act_low(act_low),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // no masked status -> pin idle on the following edge
  assert_pin_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !pend |=> (od_mode ? !irq_oe : (irq_o == act_low)));

  // ECC group clear removes the ECC bit unless a new one arrives
  assert_ecc_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(ADR_CLR) && reg_wdata[CG_ECC] && !evt_sec[2]) |=> !st2[2]);

  // unchanged content in mode 0 never raises the packet flag
  for (genvar i = 0; i < NP; i++) begin : g_chk
    assert_mode0_filter_R3: assert property (@(posedge clk) disable iff (rst)
      (!st1[i+2] && pkt_rx[i] && !pkt_mode[i] && !pkt_chg[i]) |=> !st1[i+2]);
  end
endmodule

// File: tb/vrx_irq_ctrl_bench.sv
module vrx_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] evt_link = '0;
  logic [5:0] evt_sec = '0;
  logic [1:0] evt_mute = '0;
  logic       evt_no_vinfo = 1'b0;
  logic [4:0] pkt_rx = '0;
  logic [4:0] pkt_chg = '0;
  logic       irq_o, irq_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vrx_irq_ctrl u_vrx_irq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_link(evt_link), .evt_sec(evt_sec), .evt_mute(evt_mute),
    .evt_no_vinfo(evt_no_vinfo), .pkt_rx(pkt_rx), .pkt_chg(pkt_chg),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // {link6, sec6, rx5, chg5, mute2, novinfo1, exp_st0, exp_st1, exp_st2}, pkt mode 0
  localparam logic [48:0] VEC [7] = '{
    {6'h21, 6'h00, 5'h00, 5'h00, 2'b00, 1'b0, 8'h21, 8'h00, 8'h00},
    {6'h00, 6'h0C, 5'h00, 5'h00, 2'b00, 1'b0, 8'h00, 8'h00, 8'h0C},
    {6'h00, 6'h00, 5'h01, 5'h01, 2'b00, 1'b0, 8'h00, 8'h04, 8'h00},
    {6'h00, 6'h00, 5'h1F, 5'h00, 2'b00, 1'b0, 8'h00, 8'h00, 8'h00},
    {6'h00, 6'h00, 5'h16, 5'h12, 2'b00, 1'b0, 8'h00, 8'h48, 8'h00},
    {6'h00, 6'h00, 5'h00, 5'h00, 2'b11, 1'b1, 8'h00, 8'h83, 8'h00},
    {6'h3F, 6'h3F, 5'h00, 5'h00, 2'b00, 1'b0, 8'h3F, 8'h00, 8'h3F}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [5:0] l, input logic [5:0] s, input logic [4:0] rx,
                       input logic [4:0] ch, input logic [1:0] m, input logic nv);
    @(negedge clk);
    evt_link = l; evt_sec = s; pkt_rx = rx; pkt_chg = ch; evt_mute = m; evt_no_vinfo = nv;
    @(negedge clk);
    evt_link = '0; evt_sec = '0; pkt_rx = '0; pkt_chg = '0; evt_mute = '0; evt_no_vinfo = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state R10 / R5 / R8
    rd(4'd0, d); chk("R10 st0 reset", d, 8'h00);
    rd(4'd1, d); chk("R10 st1 reset", d, 8'h00);
    rd(4'd2, d); chk("R10 st2 reset", d, 8'h00);
    rd(4'd3, d); chk("R5 mask0 reset", d, 8'h3F);
    rd(4'd4, d); chk("R5 mask1 reset", d, 8'h00);
    rd(4'd5, d); chk("R5 mask2 reset", d, 8'h00);
    rd(4'd6, d); chk("R8 pin ctrl reset", d, 8'h03);
    chk("R8 idle oe open-drain", {7'd0, irq_oe}, 8'h00);

    // vector table: R1 R2 R3 R4
    foreach (VEC[i]) begin
      pulse(VEC[i][48:43], VEC[i][42:37], VEC[i][36:32], VEC[i][31:27],
            VEC[i][26:25], VEC[i][24]);
      rd(4'd0, d); chk($sformatf("R1 vec%0d st0", i), d, VEC[i][23:16]);
      rd(4'd1, d); chk($sformatf("R2 R3 vec%0d st1", i), d, VEC[i][15:8]);
      rd(4'd2, d); chk($sformatf("R4 vec%0d st2", i), d, VEC[i][7:0]);
      wr(4'd7, 8'h7F);
    end

    // R9 latency and R8 open-drain active-low
    @(negedge clk);
    evt_link = 6'h01;
    @(negedge clk);
    evt_link = '0;
    chk("R9 one edge: pin still idle", {7'd0, irq_oe}, 8'h00);
    @(negedge clk);
    chk("R9 second edge: oe active", {7'd0, irq_oe}, 8'h01);
    chk("R8 od level active-low", {7'd0, irq_o}, 8'h00);
    rd(4'd0, d); chk("R1 sticky after strobe", d, 8'h01);

    // R8 push-pull polarities
    wr(4'd6, 8'h00);
    @(negedge clk);
    chk("R8 push-pull high oe", {7'd0, irq_oe}, 8'h01);
    chk("R8 push-pull high level", {7'd0, irq_o}, 8'h01);
    wr(4'd6, 8'h02);
    @(negedge clk);
    chk("R8 push-pull low level", {7'd0, irq_o}, 8'h00);
    wr(4'd7, 8'h01);
    @(negedge clk);
    chk("R8 push-pull low idle", {7'd0, irq_o}, 8'h01);
    chk("R8 push-pull idle oe", {7'd0, irq_oe}, 8'h01);
    wr(4'd6, 8'h03);

    // R5 masking of status 1
    pulse(6'h00, 6'h00, 5'h00, 5'h00, 2'b00, 1'b1);
    @(negedge clk);
    chk("R5 masked bit keeps pin idle", {7'd0, irq_oe}, 8'h00);
    wr(4'd4, 8'h02);
    @(negedge clk);
    chk("R5 unmasked bit drives pin", {7'd0, irq_oe}, 8'h01);
    wr(4'd4, 8'h00);
    wr(4'd7, 8'h7F);

    // R6 group clears
    pulse(6'h3F, 6'h3F, 5'h1F, 5'h1F, 2'b11, 1'b1);
    wr(4'd7, 8'h04);
    rd(4'd2, d); chk("R6 ECC clear st2", d, 8'h3B);
    rd(4'd1, d); chk("R6 ECC clear leaves st1", d, 8'hFF);
    rd(4'd0, d); chk("R6 ECC clear leaves st0", d, 8'h3F);
    wr(4'd7, 8'h10);
    rd(4'd1, d); chk("R6 clear-mute group", d, 8'h7F);
    wr(4'd7, 8'h02);
    rd(4'd1, d); chk("R6 packet group", d, 8'h01);
    wr(4'd7, 8'h40);
    rd(4'd2, d); chk("R6 auth group", d, 8'h18);
    wr(4'd7, 8'h08);
    rd(4'd2, d); chk("R6 audio group", d, 8'h00);

    // R7 event on the clear edge (status0 still 0x3F)
    @(negedge clk);
    evt_link = 6'h20;
    reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 8'h01;
    @(negedge clk);
    evt_link = '0; reg_wr = 1'b0;
    rd(4'd0, d); chk("R7 event survives clear", d, 8'h20);
    wr(4'd7, 8'h7F);

    // R3 mode 1 on SPD only
    wr(4'd8, 8'h04);
    rd(4'd8, d); chk("R3 mode readback", d, 8'h04);
    pulse(6'h00, 6'h00, 5'h06, 5'h00, 2'b00, 1'b0);
    rd(4'd1, d); chk("R3 mode1 every arrival, mode0 filtered", d, 8'h10);
    wr(4'd7, 8'h7F);

    // R10 status is read-only, clear reads zero
    wr(4'd0, 8'hFF);
    wr(4'd2, 8'hFF);
    rd(4'd0, d); chk("R10 write to st0 ignored", d, 8'h00);
    rd(4'd2, d); chk("R10 write to st2 ignored", d, 8'h00);
    rd(4'd7, d); chk("R10 clear reads zero", d, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule